// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is a clocked single-port memory with a split data path and a drive-enable output. The drive-enable output controls the three-state buffer of a shared bidirectional bus that sits outside the block. Each word is four 9-bit lanes, eight data bits plus one parity bit. Address and control are captured on the rising clock edge. Read data flows through: it comes straight from the array location held in the address register, in the same cycle as the edge that loaded that address.

Two address strobes can start an access. A processor strobe starts an access that is always a read, and it counts only when the first chip enable is active. A controller strobe can start either a read or a write. If both strobes are present, the processor strobe wins. On edges with no strobe, an advance input either steps a 2-bit wrapping burst counter or holds the current address. The counter follows a linear or an interleaved order, chosen by a mode input. Writes use a per-lane mask, and a global write forces all four lanes. In any cycle that writes, the bus is released whatever the asynchronous output enable says.

Top module: `burst_sram_ctl`

## Requirements
- R1: After reset the block is deselected, `bus_oe_o` is 0, `rdata_o` is 0 and the burst offset is cleared.
- R2: When both strobes are low on one edge and `cs1_n` is low, only the processor strobe counts, and the edge is a read even if the write inputs are active.
- R3: With `cs1_n` high the processor strobe is ignored: if `ctrl_stb_n` is high as well, no new address is loaded and the current address is kept.
- R4: The block is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. These enables are sampled only on a loading edge. While deselected, nothing is written and the bus is not driven.
- R5: An access started by the processor strobe ignores the write inputs on that edge. A write on a later edge with `adv_n`=1 goes to the loaded address.
- R6: A write occurs when `gwr_n`=0, or when `bwen_n`=0 and at least one bit of `bsel_n` is 0. If `gwr_n`=0, all lanes are written. If `bwen_n`=1 and `gwr_n`=1, nothing is written.
- R7: `bsel_n[i]` (active low) gates lane i, which is data bits [9i+8:9i]. Lane 0 is bits [8:0] and lane 3 is bits [35:27].
- R8: With `interleave`=0, the low two address bits follow start+k mod 4. k counts the advance edges since the load, and the upper address bits stay fixed.
- R9: With `interleave`=1, the low two address bits follow start XOR k.
- R10: On an edge with no strobe and `adv_n`=1, the address is held and the burst is suspended.
- R11: After an edge that writes, `bus_oe_o` is 0 whatever `oe_n` is. The bus stays released until a strobe or an advance edge without a write.
- R12: `oe_n`=1 clears `bus_oe_o` combinationally, within the cycle.
- R13: In the cycle after a read edge that selects the block coming from a deselected state, the output is masked even with `oe_n`=0.
- R14: After a read edge, `rdata_o` shows the word at the address just registered in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, captured on a loading edge |
| proc_stb_n | input | 1 | Processor address strobe, active low, read-only start |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| cs1_n | input | 1 | Chip enable 1, active low |
| cs2 | input | 1 | Chip enable 2, active high |
| cs3_n | input | 1 | Chip enable 3, active low |
| gwr_n | input | 1 | Global write, active low, all lanes |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata_i | input | LANES*LANE_W | Write data from the bus |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driving |
| bus_oe_o | output | 1 | Drive enable for the bus three-state buffer |

## Verification
Three pairs of functions can land in the same cycle. Both strobes can arrive on one edge while the write inputs are active. A write can arrive while output enable is held low. A read that follows a deselected state can arrive with output enable already low. The bench provokes each pair and compares against a behavioural model. For the strobe pair, it checks that the word at the addressed location keeps its old value. For the write pair, it checks that the drive enable drops for that cycle and stays low through a suspend that follows. For the read after deselect, it checks that the first read cycle is masked and the next one drives the stored word.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int BURST_W = 2;
  typedef logic [BURST_W-1:0] burst_idx_t;

  // low address bits for burst step k from a start offset
  function automatic burst_idx_t burst_step(input burst_idx_t start,
                                            input burst_idx_t k,
                                            input logic       ilv);
    return ilv ? (start ^ k) : burst_idx_t'(start + k);
  endfunction
endpackage

// File: rtl/sram_burst_gen.sv
module sram_burst_gen
  import sbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       adv_en,
  input  logic       interleave,
  input  burst_idx_t start_i,
  output burst_idx_t eff_o
);
  burst_idx_t start_q, k_q, start_n, k_n;

  always_comb begin
    start_n = load ? start_i : start_q;
    if (load)        k_n = '0;
    else if (adv_en) k_n = k_q + 1'b1;
    else             k_n = k_q;
    eff_o = burst_step(start_n, k_n, interleave);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      k_q     <= '0;
    end else begin
      start_q <= start_n;
      k_q     <= k_n;
    end
  end
endmodule

// File: rtl/sram_lane_mem.sv
module sram_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lane_we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              gwr_n,
  input  logic              bwen_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              oe_n,
  input  logic              interleave,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_oe_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              sel_q, rd_q, first_q;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [ADDR_W-1:0] cur_q, eff_addr;
  logic              ps_hit, load, sel_now, wdet, wr_en, adv_en;
  logic [LANES-1:0]  lane_we;
  burst_idx_t        eff_lo;
  logic [DATA_W-1:0] mem_rd;

  // strobe decode: processor strobe counts only with cs1 active, and wins
  assign ps_hit  = !proc_stb_n && !cs1_n;
  assign load    = ps_hit || !ctrl_stb_n;
  assign sel_now = !cs1_n && cs2 && !cs3_n;
  assign wdet    = !gwr_n || (!bwen_n && !(&bsel_n));
  assign lane_we = gwr_n ? ~bsel_n : {LANES{1'b1}};
  assign wr_en   = load ? (sel_now && !ps_hit && wdet) : (sel_q && wdet);
  assign adv_en  = !load && sel_q && !adv_n;

  sram_burst_gen u_burst (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .adv_en     (adv_en),
    .interleave (interleave),
    .start_i    (addr_i[BURST_W-1:0]),
    .eff_o      (eff_lo)
  );

  assign hi_n     = load ? addr_i[ADDR_W-1:BURST_W] : hi_q;
  assign eff_addr = {hi_n, eff_lo};

  sram_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk     (clk),
    .we      (wr_en),
    .lane_we (lane_we),
    .waddr   (eff_addr),
    .wdata   (wdata_i),
    .raddr   (cur_q),
    .rdata   (mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      first_q <= 1'b0;
      hi_q    <= '0;
      cur_q   <= '0;
    end else begin
      first_q <= load && sel_now && !sel_q;
      if (load) begin
        sel_q <= sel_now;
        hi_q  <= hi_n;
        cur_q <= eff_addr;
        rd_q  <= sel_now && !wr_en;
      end else if (sel_q) begin
        cur_q <= eff_addr;
        if (wr_en)       rd_q <= 1'b0;
        else if (adv_en) rd_q <= 1'b1;
      end else begin
        rd_q <= 1'b0;
      end
    end
  end

  // output enable is asynchronous; write cycles and first read mask it
  assign bus_oe_o = rd_q && !oe_n && !first_q;
  assign rdata_o  = bus_oe_o ? mem_rd : '0;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_stb_n,
  input logic              cs1_n,
  input logic              cs3_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              bus_oe_o,
  input logic              wr_en,
  input logic              load,
  input logic              sel_q,
  input logic [ADDR_W-1:0] cur_q
);
  a_r11_write_tristate: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !bus_oe_o);

  a_r13_first_read_masked: assert property (@(posedge clk) disable iff (rst)
    (load && !sel_q) |=> !bus_oe_o);

  a_r10_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && sel_q && adv_n) |=> $stable(cur_q));

  a_r2_proc_start_reads: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && !cs1_n) |-> !wr_en);

  a_r4_deselect_no_write: assert property (@(posedge clk) disable iff (rst)
    (load && cs3_n) |-> !wr_en);

  a_r12_oe_gates: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !bus_oe_o);
endmodule

bind burst_sram_ctl sbc_checker #(.ADDR_W(ADDR_W)) u_sbc_chk (
  .clk        (clk),
  .rst        (rst),
  .proc_stb_n (proc_stb_n),
  .cs1_n      (cs1_n),
  .cs3_n      (cs3_n),
  .adv_n      (adv_n),
  .oe_n       (oe_n),
  .bus_oe_o   (bus_oe_o),
  .wr_en      (wr_en),
  .load       (load),
  .sel_q      (sel_q),
  .cur_q      (cur_q)
);

// File: tb/tb_burst_sram_ctl.sv
`timescale 1ns/1ps
module tb_burst_sram_ctl;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
  logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic          gwr_n = 1'b1, bwen_n = 1'b1, oe_n = 1'b0, interleave = 1'b0;
  logic [3:0]    bsel_n = 4'hf;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          bus_oe_o;

  int checks = 0;
  int errors = 0;

  burst_sram_ctl #(.ADDR_W(AW), .LANE_W(9), .LANES(4)) dut (.*);

  always #2.5 clk = ~clk;

  // reference model state
  logic [DW-1:0] m_mem [64];
  bit            m_sel, m_rd, m_first;
  logic [1:0]    m_start, m_k;
  logic [3:0]    m_hi;
  logic [AW-1:0] m_cur;

  function automatic logic [DW-1:0] pat(input int i);
    return {4'(i) ^ 4'h9, 32'(i) * 32'h0103_0507 + 32'h00a0_0f00};
  endfunction

  task automatic check(input string tag, input logic cond,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit ps, ld, wd, wr, nsel;
    ps = !proc_stb_n && !cs1_n;
    ld = ps || !ctrl_stb_n;
    wd = !gwr_n || (!bwen_n && bsel_n != 4'hf);
    wr = 0;
    if (ld) begin
      nsel    = !cs1_n && cs2 && !cs3_n;
      m_first = nsel && !m_sel;
      m_sel   = nsel;
      m_start = addr_i[1:0];
      m_k     = 2'd0;
      m_hi    = addr_i[5:2];
      m_cur   = addr_i;
      wr      = nsel && !ps && wd;
      m_rd    = nsel && !wr;
    end else begin
      m_first = 0;
      if (m_sel) begin
        if (!adv_n) m_k = m_k + 2'd1;
        m_cur = {m_hi, interleave ? (m_start ^ m_k) : 2'(m_start + m_k)};
        wr = wd;
        if (wr) m_rd = 0;
        else if (!adv_n) m_rd = 1;
      end else begin
        m_rd = 0;
      end
    end
    if (wr)
      for (int l = 0; l < 4; l++)
        if (!gwr_n || !bsel_n[l]) m_mem[m_cur][l*9 +: 9] = wdata_i[l*9 +: 9];
  endtask

  // one clock: model follows the edge, outputs compared mid-cycle
  task automatic tick(input string tag);
    logic exp_oe;
    logic [DW-1:0] exp_d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_oe = m_rd && !oe_n && !m_first;
    exp_d  = exp_oe ? m_mem[m_cur] : '0;
    check({tag, " drive"}, bus_oe_o === exp_oe, DW'(bus_oe_o), DW'(exp_oe));
    check({tag, " data"}, rdata_o === exp_d, rdata_o, exp_d);
  endtask

  task automatic quiet();
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
    gwr_n = 1; bwen_n = 1; bsel_n = 4'hf;
  endtask

  task automatic sel_on();
    cs1_n = 0; cs2 = 1; cs3_n = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_sel = 0; m_rd = 0; m_first = 0; m_start = 0; m_k = 0; m_hi = 0; m_cur = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, no drive even with oe low
    check("R1 reset drive", bus_oe_o === 1'b0, DW'(bus_oe_o), '0);
    check("R1 reset data", rdata_o === '0, rdata_o, '0);
    tick("R1");

    // R6: fill with global writes through the controller strobe
    sel_on();
    for (int i = 0; i < 64; i++) begin
      ctrl_stb_n = 0; gwr_n = 0; bsel_n = 4'hf; addr_i = AW'(i); wdata_i = pat(i);
      tick("R6 fill");
    end
    quiet();
    cs1_n = 1; ctrl_stb_n = 0;          // controller strobe deselects
    tick("R4 deselect");
    quiet();

    // R13: first read after deselect is masked, then R10 suspend drives
    sel_on(); proc_stb_n = 0; addr_i = 6'd5;
    tick("R13");
    quiet();
    tick("R10 R14");
    tick("R10");

    // R8 linear burst from offset 2, wraps
    interleave = 0; proc_stb_n = 0; addr_i = 6'd6;
    tick("R14");
    quiet(); adv_n = 0;
    for (int i = 0; i < 5; i++) tick("R8");

    // R9 interleaved burst from offset 1
    quiet(); interleave = 1; proc_stb_n = 0; addr_i = 6'd9;
    tick("R9");
    quiet(); adv_n = 0;
    for (int i = 0; i < 4; i++) tick("R9");
    interleave = 0;

    // R2: both strobes, write inputs active: read only
    quiet(); proc_stb_n = 0; ctrl_stb_n = 0; gwr_n = 0; wdata_i = '1; addr_i = 6'd12;
    tick("R2");
    quiet();
    tick("R2 keep");

    // R12: oe asynchronous within the cycle
    oe_n = 1; #1;
    check("R12 off", bus_oe_o === 1'b0, DW'(bus_oe_o), '0);
    oe_n = 0; #1;
    check("R12 on", bus_oe_o === 1'b1 && rdata_o === m_mem[12], rdata_o, m_mem[12]);

    // R3: processor strobe with cs1 high is ignored
    cs1_n = 1; proc_stb_n = 0; addr_i = 6'd40;
    tick("R3");
    quiet(); sel_on();
    tick("R3 hold");

    // R5: processor start ignores writes, next edge writes loaded address
    proc_stb_n = 0; addr_i = 6'd20; gwr_n = 0; wdata_i = 36'h1_2345_6789;
    tick("R5 start");
    proc_stb_n = 1; gwr_n = 0;
    tick("R5 R11 write");
    quiet();
    tick("R11 stays off");
    adv_n = 0;
    tick("R11 advance");
    quiet(); proc_stb_n = 0; addr_i = 6'd20;
    tick("R5 reload");
    quiet();
    tick("R5 readback");

    // R7: byte write lanes 0 and 2
    ctrl_stb_n = 0; addr_i = 6'd30; bwen_n = 0; bsel_n = 4'b1010; wdata_i = 36'hf_edcb_a987;
    tick("R7 write");
    quiet(); ctrl_stb_n = 0; addr_i = 6'd30;
    tick("R7 readback");
    // R6: selects low without byte-write enable: no write
    quiet(); ctrl_stb_n = 0; addr_i = 6'd31; bsel_n = 4'h0; wdata_i = '0;
    tick("R6 no write");
    quiet();
    tick("R6 readback");

    // R4: cs3 high on a write load: deselected, nothing written
    ctrl_stb_n = 0; cs3_n = 1; gwr_n = 0; addr_i = 6'd33; wdata_i = '0;
    tick("R4 write ignored");
    quiet(); sel_on(); proc_stb_n = 0; addr_i = 6'd33;
    tick("R4 first");
    quiet();
    tick("R4 readback");

    // R11: write with oe low via controller strobe
    ctrl_stb_n = 0; gwr_n = 0; addr_i = 6'd50; wdata_i = 36'h0_5555_aaaa;
    tick("R11 oe low");
    quiet(); adv_n = 0;
    tick("R11 resume");

    quiet();
    tick("R10 end");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule